// File: doc/BRIEF.md
# Software-Driven I2C Pin Controller

This block hands direct control of the two I2C bus wires to software. A processor reaches it over a 32-bit peripheral bus in the APB style. Writes move a two-bit drive register through one address that only raises bits and another that only lowers them, so software never needs a read-modify-write to toggle a single wire. Each drive bit feeds an open-drain pad. A 0 pulls its wire low. A 1 lets the wire float up to the external pull-up.

Software generates start, stop, clock pulses and data bits itself by writing in sequence. It reads one status word that holds the clock bit as currently driven and the data wire as actually seen on the bus. The data wire is resynchronised before it is read, so an acknowledge driven low by a target device shows up even while the controller itself has released the line. Any access to an offset that the block does not implement reads as all ones. Such an access leaves the drive register untouched and sets a sticky error flag.

Top module: `i2c_pin_ctrl`

## Requirements
- R1: Reset (rst_ni low, asynchronous) loads the drive register with 2'b11, so both output enables read 0. The error flag is 0, and a status read right after reset returns 0x3.
- R2: A write to offset 0x0 ORs write-data bits [1:0] into the drive register, where bit 0 is the clock wire and bit 1 is the data wire. Write-data bits [31:2] have no effect.
- R3: A write to offset 0x4 clears each drive-register bit whose write-data bit is 1 and leaves every other bit as it was.
- R4: A read of offset 0x0 returns the drive-register clock bit in bit 0 and the synchronised data-wire level in bit 1. Bits [31:2] are 0. Bit 1 follows the wire, not the drive register.
- R5: A read of any offset other than 0x0, 0x4 included, returns 0xFFFFFFFF.
- R6: A write to any offset other than 0x0 and 0x4 leaves the drive register unchanged.
- R7: Only address bits [11:0] form the offset, so the register pair repeats every 4 KB. For example, 0x1004 acts as 0x4 and 0x2000 acts as 0x0.
- R8: The pads are open-drain. The output value is always 0, and the output enable is the inverse of the drive bit. The pads reflect a write in the cycle after its access edge.
- R9: The data wire passes through a two-flop synchronizer with reset value 1. A change on sda_i becomes visible in read data only after two rising clock edges.
- R10: An access phase (psel_i and penable_i high) to an unsupported offset sets err_o. That covers reads other than 0x0 and writes other than 0x0 or 0x4. err_o stays set until reset.
- R11: A transfer takes effect only in its access phase. A setup phase with penable_i low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Peripheral select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W (32) | Byte address |
| pwdata_i | input | DATA_W (32) | Write data |
| prdata_o | output | DATA_W (32) | Read data, valid while psel_i is high and pwrite_i is low |
| err_o | output | 1 | Sticky bad-offset flag |
| scl_o | output | 1 | Clock pad output value (always 0) |
| scl_oe_o | output | 1 | Clock pad output enable (1 = pull low) |
| sda_o | output | 1 | Data pad output value (always 0) |
| sda_oe_o | output | 1 | Data pad output enable (1 = pull low) |
| sda_i | input | 1 | Data wire level from the pad |

## Verification
The bench reads the status word while the controller releases the data wire and an external device holds it low. A design that returned the drive register in bit 1 would report a high wire there. It reads the wire in the cycle right after the wire changes, so a design with a single synchroniser flop shows the new level one read too early. It writes to unsupported offsets and to aliased addresses above 4 KB with data that would visibly move the pads. A design that decoded more than 12 bits, or treated a bad offset as set or clear, would change or keep the wrong enables. It also holds a write in its setup phase without an access phase, so a design that latched on psel_i alone would move a pad. Finally, it checks that the error flag survives later good accesses and clears only on reset.

// File: rtl/i2c_pin_pkg.sv
package i2c_pin_pkg;
  localparam int PIN_N   = 2;
  localparam int SCL_BIT = 0;
  localparam int SDA_BIT = 1;
  localparam int SET_OFS = 'h0;
  localparam int CLR_OFS = 'h4;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_SET,
    ACC_CLR,
    ACC_BAD
  } acc_e;
endpackage

// File: rtl/i2c_pin_dec.sv
module i2c_pin_dec
  import i2c_pin_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic             psel_i,
  input  logic             penable_i,
  input  logic             pwrite_i,
  input  logic [OFS_W-1:0] ofs_i,
  output acc_e             acc_o,
  output logic             rd_stat_o,
  output logic             rd_bad_o
);
  logic hit_set, hit_clr, rd;

  assign hit_set = (ofs_i == OFS_W'(SET_OFS));
  assign hit_clr = (ofs_i == OFS_W'(CLR_OFS));
  assign rd      = psel_i && !pwrite_i;

  // read data is driven for the whole transfer, both phases
  assign rd_stat_o = rd && hit_set;
  assign rd_bad_o  = rd && !hit_set;

  always_comb begin
    acc_o = ACC_NONE;
    if (psel_i && penable_i) begin
      if (pwrite_i) begin
        if (hit_set)      acc_o = ACC_SET;
        else if (hit_clr) acc_o = ACC_CLR;
        else              acc_o = ACC_BAD;
      end else if (!hit_set) begin
        acc_o = ACC_BAD;
      end
    end
  end
endmodule

// File: rtl/i2c_pin_latch.sv
module i2c_pin_latch #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '1;
    else if (clr_i) q_o <= q_o & ~wd_i;
    else if (set_i) q_o <= q_o | wd_i;
  end
endmodule

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] r;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("i2c_pin_sync: STAGES must be >= 2");
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r <= {STAGES{RST_VAL}};
    else         r <= {r[STAGES-2:0], d_i};
  end

  assign q_o = r[STAGES-1];
endmodule

// File: rtl/i2c_od_pad.sv
module i2c_od_pad (
  input  logic drive_i,
  output logic o_o,
  output logic oe_o
);
  // 0 pulls low, 1 releases to the pull-up
  assign o_o  = 1'b0;
  assign oe_o = ~drive_i;
endmodule

// File: rtl/i2c_pin_ctrl.sv
module i2c_pin_ctrl
  import i2c_pin_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int OFS_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              err_o,
  output logic              scl_o,
  output logic              scl_oe_o,
  output logic              sda_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  acc_e             acc;
  logic             rd_stat, rd_bad, sda_s;
  logic [PIN_N-1:0] drv, pad_o, pad_oe;
  logic             unused_hi;

  assign unused_hi = ^{paddr_i[ADDR_W-1:OFS_W], pwdata_i[DATA_W-1:PIN_N]};

  i2c_pin_dec #(.OFS_W(OFS_W)) u_dec (
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .ofs_i     (paddr_i[OFS_W-1:0]),
    .acc_o     (acc),
    .rd_stat_o (rd_stat),
    .rd_bad_o  (rd_bad)
  );

  i2c_pin_latch #(.W(PIN_N)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (acc == ACC_SET),
    .clr_i  (acc == ACC_CLR),
    .wd_i   (pwdata_i[PIN_N-1:0]),
    .q_o    (drv)
  );

  i2c_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sda_i),
    .q_o    (sda_s)
  );

  for (genvar i = 0; i < PIN_N; i++) begin : g_pad
    i2c_od_pad u_pad (
      .drive_i (drv[i]),
      .o_o     (pad_o[i]),
      .oe_o    (pad_oe[i])
    );
  end

  assign scl_o    = pad_o[SCL_BIT];
  assign scl_oe_o = pad_oe[SCL_BIT];
  assign sda_o    = pad_o[SDA_BIT];
  assign sda_oe_o = pad_oe[SDA_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             err_o <= 1'b0;
    else if (acc == ACC_BAD) err_o <= 1'b1;
  end

  always_comb begin
    prdata_o = '0;
    if (rd_stat) begin
      prdata_o[SCL_BIT] = drv[SCL_BIT];
      prdata_o[SDA_BIT] = sda_s;
    end else if (rd_bad) begin
      prdata_o = '1;
    end
  end
endmodule

// File: rtl/i2c_pin_ctrl_chk.sv
module i2c_pin_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [OFS_W-1:0]  ofs_i,
  input logic [1:0]        wd_i,
  input logic [DATA_W-1:0] prdata_o,
  input logic              err_o,
  input logic              scl_oe_o,
  input logic              sda_oe_o
);
  logic acc, wr_set, wr_clr, wr_bad, rd_bad, rd_stat;
  assign acc     = psel_i && penable_i;
  assign wr_set  = acc && pwrite_i && ofs_i == OFS_W'(0);
  assign wr_clr  = acc && pwrite_i && ofs_i == OFS_W'(4);
  assign wr_bad  = acc && pwrite_i && ofs_i != OFS_W'(0) && ofs_i != OFS_W'(4);
  assign rd_bad  = psel_i && !pwrite_i && ofs_i != OFS_W'(0);
  assign rd_stat = psel_i && !pwrite_i && ofs_i == OFS_W'(0);

  // R2
  set_scl_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_set && wd_i[0]) |=> !scl_oe_o);

  // R3
  clr_sda_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && wd_i[1]) |=> sda_oe_o);

  // R6
  bad_wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_bad |=> $stable({scl_oe_o, sda_oe_o}));

  // R5
  bad_rd_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_bad |-> prdata_o == '1);

  // R4
  stat_rd_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |-> (prdata_o[DATA_W-1:2] == '0 && prdata_o[0] == !scl_oe_o));

  // R10
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((acc && rd_bad) || wr_bad) |=> err_o);

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R11
  setup_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc) |=> $stable({scl_oe_o, sda_oe_o}));
endmodule

bind i2c_pin_ctrl i2c_pin_ctrl_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .psel_i    (psel_i),
  .penable_i (penable_i),
  .pwrite_i  (pwrite_i),
  .ofs_i     (paddr_i[OFS_W-1:0]),
  .wd_i      (pwdata_i[1:0]),
  .prdata_o  (prdata_o),
  .err_o     (err_o),
  .scl_oe_o  (scl_oe_o),
  .sda_oe_o  (sda_oe_o)
);

// File: tb/sim_i2c_pin_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_pin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0] paddr = '0, pwdata = '0;
  logic [31:0] prdata;
  logic        err, scl_o, scl_oe, sda_o, sda_oe;
  logic        ext_low = 1'b0;
  logic        sda_line;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] val;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  // wired-AND bus with pull-up
  assign sda_line = !sda_oe && !ext_low;

  i2c_pin_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .err_o(err), .scl_o(scl_o), .scl_oe_o(scl_oe),
    .sda_o(sda_o), .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks start and end at posedge+1
  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge clk); #1 penable = 1'b1;
    @(posedge clk); #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] a, input logic [31:0] e, input string req);
    exp_t it;
    it.val = e; it.req = req;
    exp_q.push_back(it);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(posedge clk); #1 penable = 1'b1;
    @(posedge clk); #1 psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_pads(input logic scl_e, input logic sda_e, input string req);
    check({30'b0, scl_oe, sda_oe}, {30'b0, scl_e, sda_e}, req);
  endtask

  // monitor: compare read data in the access phase
  always @(negedge clk) begin
    if (rst_n && psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL monitor: actual=%h expected=none", prdata);
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        check(prdata, it.val, it.req);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check_pads(1'b0, 1'b0, "R1 pads");
    check({31'b0, err}, 32'h0, "R1 err");
    check({30'b0, scl_o, sda_o}, 32'h0, "R8 pad values");
    bus_read(32'h0, 32'h3, "R1 status");

    // R3 clear clock only
    bus_write(32'h4, 32'h1);
    check_pads(1'b1, 1'b0, "R3/R8 clr scl");
    bus_read(32'h0, 32'h2, "R4 scl low");
    bus_write(32'h4, 32'h2);
    check_pads(1'b1, 1'b1, "R3 clr sda");
    idle(3);
    bus_read(32'h0, 32'h0, "R4 both low");

    // R2 set, upper data ignored
    bus_write(32'h0, 32'hFFFF_FFFD);
    check_pads(1'b0, 1'b1, "R2 set scl only");
    idle(3);
    bus_read(32'h0, 32'h1, "R2 status");
    bus_write(32'h0, 32'h2);
    check_pads(1'b0, 1'b0, "R2 set sda");
    idle(3);
    bus_read(32'h0, 32'h3, "R4 released");

    // R9 two-flop delay; R4 bit1 follows wire
    ext_low = 1'b1;
    bus_read(32'h0, 32'h3, "R9 old level");
    bus_read(32'h0, 32'h1, "R9/R4 wire low");
    ext_low = 1'b0;
    idle(3);

    // R5/R10 bad reads
    check({31'b0, err}, 32'h0, "R10 no err yet");
    bus_read(32'h4, 32'hFFFF_FFFF, "R5 read clr ofs");
    check({31'b0, err}, 32'h1, "R10 err set");
    bus_read(32'h8, 32'hFFFF_FFFF, "R5 read 0x8");
    bus_write(32'h0, 32'h3);
    check({31'b0, err}, 32'h1, "R10 err sticky");

    // R6 bad writes
    bus_write(32'h4, 32'h3);
    check_pads(1'b1, 1'b1, "R3 clr both");
    bus_write(32'h8, 32'h3);
    bus_write(32'h10, 32'hFFFF_FFFF);
    bus_write(32'hFFC, 32'h3);
    check_pads(1'b1, 1'b1, "R6 bad writes hold");
    bus_write(32'h0, 32'h3);
    check_pads(1'b0, 1'b0, "R2 restore");

    // R7 aliasing
    bus_write(32'h1004, 32'h1);
    check_pads(1'b1, 1'b0, "R7 clr alias");
    bus_read(32'h2000, 32'h2, "R7 read alias");
    bus_read(32'h1008, 32'hFFFF_FFFF, "R7 bad alias");
    bus_write(32'h3000, 32'h1);
    check_pads(1'b0, 1'b0, "R7 set alias");

    // R11 setup phase only
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 32'h4; pwdata = 32'h3;
    @(posedge clk); #1 psel = 1'b0; pwrite = 1'b0;
    idle(1);
    check_pads(1'b0, 1'b0, "R11 setup only");

    // R10/R1 reset clears flag and latch
    bus_write(32'h4, 32'h3);
    rst_n = 1'b0;
    #2;
    check({31'b0, err}, 32'h0, "R10 err reset");
    check_pads(1'b0, 1'b0, "R1 async reset");
    idle(1);
    rst_n = 1'b1;
    idle(3);
    bus_read(32'h0, 32'h3, "R1 status after reset");

    idle(2);
    check(exp_q.size(), 0, "scoreboard drained");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule